// File: doc/BRIEF.md
# UART Register Block with Receive Queue

This block is the software-facing side of a UART. A host reaches it over a simple single-cycle bus: a select strobe, a write flag, a 12-bit byte offset and 32-bit data. Read data and an access-error pulse come back one clock after the access. The block holds the configuration registers: control, line settings, baud divisor halves, receive level select, interrupt mask and DMA control. It exposes a read-only flag word, raw and masked interrupt status, and a write-one-to-clear interrupt word. A read-only identification window sits at the top of the offset space, and one of two byte tables is chosen by a static input.

Received characters come in through a byte-plus-valid port. A separate break input pushes a flagged entry instead of a byte. Both feed a circular receive queue of 16 entries. When the queue is disabled in the line settings it behaves as a single holding slot. A bus read of the data word pops the oldest entry. A bus write of the data word emits the byte for one cycle on the transmit output. The interrupt line is a registered OR of the raw status bits that the mask enables.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset, the flag word (0x018) reads 0x90 and control (0x004) reads 0x300. Level select (0x034) reads 0x12. Line settings (0x02C), mask (0x038), raw status (0x03C) and DMA control (0x048) read 0. The irq, tx_valid and bus_err outputs are 0.
- R2: With line settings bit 4 set, the queue accepts 16 entries and returns them in arrival order, wrapping correctly around the end of its storage.
- R3: With line settings bit 4 clear, the queue holds at most one entry, and a further arrival does not change its content.
- R4: Flag word layout: bit 4 is receive-empty (count is 0). Bit 6 is receive-full (count has reached capacity, which is 16 when enabled and 1 when disabled). Bit 7 (transmit-empty) always reads 1 and bit 5 (transmit-full) always reads 0.
- R5: A break pulse pushes the entry 0x400 (bit 10 set, byte zero). When a break and a character arrive in the same cycle, only the break entry is stored.
- R6: An arrival while the queue is at capacity is dropped and sets raw status bit 10. Writing a 1 to that bit of the clear word (0x044) clears it.
- R7: A read of the data word (0x000) returns the oldest entry and removes it. A read while the queue is empty returns 0 and changes nothing.
- R8: Raw status bit 4 is set when an accepted arrival brings the count to the trigger level, and cleared when a pop leaves the count below it. The trigger is 1 when the queue is disabled. Otherwise it is 2, 4, 8, 12 or 14 for level select bits 5:3 equal to 0, 1, 2, 3 or 4 and above.
- R9: irq goes high one cycle after raw status ANDed with the mask becomes nonzero, and low one cycle after it becomes zero. The masked status word (0x040) reads that AND.
- R10: A write to the data word drives tx_valid high for exactly one cycle, with tx_char equal to write data bits 7:0, and sets raw status bit 5.
- R11: A read at offsets 0xFE0 to 0xFFC returns one identification byte from the table picked by id_variant, indexed by offset bits 4:2. Variant 0 is 11 10 14 00 0D F0 05 B1 and variant 1 is 11 00 18 01 0D F0 05 B1.
- R12: Writes to the flag word (0x018) are ignored.
- R13: A read or write at an offset that is not mapped, or is not word aligned, reads 0, changes no state, and raises bus_err for one cycle alongside the read data.
- R14: Writable registers keep their declared widths: control 32 bits, baud integer (0x024) 16 bits, baud fraction (0x028) 6 bits, line settings 8 bits, level select 6 bits, mask 11 bits and DMA control 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| bus_err | output | 1 | One-cycle pulse for an access to an unmapped offset |
| id_variant | input | 1 | Selects the identification table |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | Break condition pulse |
| tx_valid | output | 1 | One-cycle pulse carrying a transmitted byte |
| tx_char | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that rx_valid and rx_break are single-cycle events offered without any ready handshake. They also assume each bus access is a one-cycle strobe, so that an access in cycle N is answered in cycle N+1. The stimulus tasks return every strobe and event input to idle before the next operation starts. id_variant is changed only while the bus is idle, and reset is applied only at the start of the run. The sequence of tests carries queue state from one test to the next, so the wrap-around of the read position is reached without any back-door access.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int WORD_DATA   = 0;
  localparam int WORD_CTRL   = 1;
  localparam int WORD_FLAG   = 6;
  localparam int WORD_BAUD_I = 9;
  localparam int WORD_BAUD_F = 10;
  localparam int WORD_LINE   = 11;
  localparam int WORD_LEVEL  = 13;
  localparam int WORD_MASK   = 14;
  localparam int WORD_RAW    = 15;
  localparam int WORD_MASKED = 16;
  localparam int WORD_CLEAR  = 17;
  localparam int WORD_DMA    = 18;

  localparam int RAW_W      = 11;
  localparam int ST_RX      = 4;
  localparam int ST_TX      = 5;
  localparam int ST_OVR     = 10;

  localparam int BREAK_BIT  = 10;
  localparam int ENTRY_W    = BREAK_BIT + 1;

  localparam int FL_RX_EMPTY = 4;
  localparam int FL_TX_FULL  = 5;
  localparam int FL_RX_FULL  = 6;
  localparam int FL_TX_EMPTY = 7;

  localparam int LINE_QEN   = 4;

  localparam logic [31:0] CTRL_RST  = 32'h0000_0300;
  localparam logic [5:0]  LEVEL_RST = 6'h12;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_CTRL,
    SEL_FLAG,
    SEL_BAUD_I,
    SEL_BAUD_F,
    SEL_LINE,
    SEL_LEVEL,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLEAR,
    SEL_DMA,
    SEL_ID
  } reg_sel_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic [2:0]        id_idx
);

  int widx;

  always_comb begin
    widx   = int'(addr[ADDR_W-1:2]);
    id_idx = addr[4:2];
    sel    = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (&addr[ADDR_W-1:5]) begin
        sel = SEL_ID;
      end else begin
        case (widx)
          WORD_DATA:   sel = SEL_DATA;
          WORD_CTRL:   sel = SEL_CTRL;
          WORD_FLAG:   sel = SEL_FLAG;
          WORD_BAUD_I: sel = SEL_BAUD_I;
          WORD_BAUD_F: sel = SEL_BAUD_F;
          WORD_LINE:   sel = SEL_LINE;
          WORD_LEVEL:  sel = SEL_LEVEL;
          WORD_MASK:   sel = SEL_MASK;
          WORD_RAW:    sel = SEL_RAW;
          WORD_MASKED: sel = SEL_MASKED;
          WORD_CLEAR:  sel = SEL_CLEAR;
          WORD_DMA:    sel = SEL_DMA;
          default:     sel = SEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom (
  input  logic       variant,
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);

  always_comb begin
    case ({variant, idx})
      4'h0: id_byte = 8'h11;
      4'h1: id_byte = 8'h10;
      4'h2: id_byte = 8'h14;
      4'h3: id_byte = 8'h00;
      4'h4: id_byte = 8'h0D;
      4'h5: id_byte = 8'hF0;
      4'h6: id_byte = 8'h05;
      4'h7: id_byte = 8'hB1;
      4'h8: id_byte = 8'h11;
      4'h9: id_byte = 8'h00;
      4'hA: id_byte = 8'h18;
      4'hB: id_byte = 8'h01;
      4'hC: id_byte = 8'h0D;
      4'hD: id_byte = 8'hF0;
      4'hE: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             cap_one,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    cnt_next,
  output logic             accepted,
  output logic             popped,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    wr_slot;
  logic [CW-1:0]    cap;

  always_comb begin
    cap      = cap_one ? CW'(1) : CW'(DEPTH);
    full     = (count >= cap);
    accepted = push && !full;
    popped   = pop && (count != '0);
    wr_slot  = rd_ptr + count[AW-1:0];
    cnt_next = count + CW'(accepted) - CW'(popped);
    dout     = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_slot] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (popped) rd_ptr <= rd_ptr + AW'(1);
      count <= cnt_next;
    end
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CHAR_W   = 8,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              id_variant,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_break,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  output logic              irq
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [DATA_W-1:0] ctrl_q;
  logic [15:0]       baud_i_q;
  logic [5:0]        baud_f_q;
  logic [7:0]        line_q;
  logic [5:0]        level_q;
  logic [RAW_W-1:0]  mask_q;
  logic [RAW_W-1:0]  raw_q;
  logic [RAW_W-1:0]  raw_n;
  logic [2:0]        dma_q;

  reg_sel_t          sel;
  logic [2:0]        id_idx;
  logic [7:0]        id_byte;
  logic              rd_acc;
  logic              wr_acc;
  logic              fifo_en;

  logic              rx_push;
  logic [ENTRY_W-1:0] rx_entry;
  logic [ENTRY_W-1:0] rx_head;
  logic [CNT_W-1:0]  rx_count;
  logic [CNT_W-1:0]  rx_cnt_next;
  logic              rx_accepted;
  logic              rx_popped;
  logic              rx_full;
  logic [CNT_W-1:0]  trig;
  logic [7:0]        flag_w;
  logic [DATA_W-1:0] rdata_n;

  assign rd_acc  = bus_sel && !bus_wr;
  assign wr_acc  = bus_sel && bus_wr;
  assign fifo_en = line_q[LINE_QEN];

  uart_rf_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr   (bus_addr),
    .sel    (sel),
    .id_idx (id_idx)
  );

  uart_id_rom id_i (
    .variant (id_variant),
    .idx     (id_idx),
    .id_byte (id_byte)
  );

  always_comb begin
    rx_push  = rx_valid || rx_break;
    rx_entry = rx_break ? ENTRY_W'(1) << BREAK_BIT : ENTRY_W'(rx_char);
  end

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(ENTRY_W)) fifo_i (
    .clk      (clk),
    .rst      (rst),
    .push     (rx_push),
    .pop      (rd_acc && (sel == SEL_DATA)),
    .cap_one  (!fifo_en),
    .din      (rx_entry),
    .dout     (rx_head),
    .count    (rx_count),
    .cnt_next (rx_cnt_next),
    .accepted (rx_accepted),
    .popped   (rx_popped),
    .full     (rx_full)
  );

  // Receive trigger level as a fraction of the queue depth.
  always_comb begin
    if (!fifo_en) begin
      trig = CNT_W'(1);
    end else begin
      case (level_q[5:3])
        3'd0:    trig = CNT_W'(RX_DEPTH / 8);
        3'd1:    trig = CNT_W'(RX_DEPTH / 4);
        3'd2:    trig = CNT_W'(RX_DEPTH / 2);
        3'd3:    trig = CNT_W'((RX_DEPTH * 3) / 4);
        default: trig = CNT_W'((RX_DEPTH * 7) / 8);
      endcase
    end
  end

  always_comb begin
    flag_w              = '0;
    flag_w[FL_RX_EMPTY] = (rx_count == '0);
    flag_w[FL_RX_FULL]  = rx_full;
    flag_w[FL_TX_FULL]  = 1'b0;
    flag_w[FL_TX_EMPTY] = 1'b1;
  end

  // Raw interrupt status: explicit clear first, then hardware events win.
  always_comb begin
    raw_n = raw_q;
    if (wr_acc && (sel == SEL_CLEAR)) raw_n = raw_n & ~bus_wdata[RAW_W-1:0];
    if (rx_popped && (rx_cnt_next < trig)) raw_n[ST_RX] = 1'b0;
    if (rx_accepted && (rx_cnt_next >= trig)) raw_n[ST_RX] = 1'b1;
    if (rx_push && !rx_accepted) raw_n[ST_OVR] = 1'b1;
    if (wr_acc && (sel == SEL_DATA)) raw_n[ST_TX] = 1'b1;
  end

  always_comb begin
    rdata_n = '0;
    case (sel)
      SEL_DATA:   rdata_n = (rx_count != '0) ? DATA_W'(rx_head) : '0;
      SEL_CTRL:   rdata_n = ctrl_q;
      SEL_FLAG:   rdata_n = DATA_W'(flag_w);
      SEL_BAUD_I: rdata_n = DATA_W'(baud_i_q);
      SEL_BAUD_F: rdata_n = DATA_W'(baud_f_q);
      SEL_LINE:   rdata_n = DATA_W'(line_q);
      SEL_LEVEL:  rdata_n = DATA_W'(level_q);
      SEL_MASK:   rdata_n = DATA_W'(mask_q);
      SEL_RAW:    rdata_n = DATA_W'(raw_q);
      SEL_MASKED: rdata_n = DATA_W'(raw_q & mask_q);
      SEL_DMA:    rdata_n = DATA_W'(dma_q);
      SEL_ID:     rdata_n = DATA_W'(id_byte);
      default:    rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      baud_i_q <= '0;
      baud_f_q <= '0;
      line_q   <= '0;
      level_q  <= LEVEL_RST;
      mask_q   <= '0;
      dma_q    <= '0;
    end else if (wr_acc) begin
      case (sel)
        SEL_CTRL:   ctrl_q   <= bus_wdata;
        SEL_BAUD_I: baud_i_q <= bus_wdata[15:0];
        SEL_BAUD_F: baud_f_q <= bus_wdata[5:0];
        SEL_LINE:   line_q   <= bus_wdata[7:0];
        SEL_LEVEL:  level_q  <= bus_wdata[5:0];
        SEL_MASK:   mask_q   <= bus_wdata[RAW_W-1:0];
        SEL_DMA:    dma_q    <= bus_wdata[2:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_char   <= '0;
      irq       <= 1'b0;
    end else begin
      raw_q     <= raw_n;
      bus_rdata <= rd_acc ? rdata_n : '0;
      bus_err   <= bus_sel && (sel == SEL_NONE);
      tx_valid  <= wr_acc && (sel == SEL_DATA);
      if (wr_acc && (sel == SEL_DATA)) tx_char <= bus_wdata[CHAR_W-1:0];
      irq       <= |(raw_q & mask_q);
    end
  end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RX_DEPTH = 16,
  localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_err,
  input logic              rx_valid,
  input logic              rx_break,
  input logic              tx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic              fifo_en,
  input logic [RAW_W-1:0]  raw,
  input logic [RAW_W-1:0]  mask
);

  logic arrive;
  logic data_rd;
  logic data_wr;

  assign arrive  = rx_valid || rx_break;
  assign data_rd = bus_sel && !bus_wr && (bus_addr == '0);
  assign data_wr = bus_sel && bus_wr && (bus_addr == '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(RX_DEPTH)); // R2

  AST_SINGLE_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && (count != '0) && arrive && !data_rd) |=> (count == $past(count))); // R3

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (arrive && (count >= (fifo_en ? CNT_W'(RX_DEPTH) : CNT_W'(1)))) |=> raw[ST_OVR]); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((raw & mask) == '0) |=> !irq); // R9

  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(data_wr)); // R10

  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel)); // R13

endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_err  (bus_err),
  .rx_valid (rx_valid),
  .rx_break (rx_break),
  .tx_valid (tx_valid),
  .irq      (irq),
  .count    (rx_count),
  .fifo_en  (fifo_en),
  .raw      (raw_q),
  .mask     (mask_q)
);

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;

  localparam logic [11:0] A_DATA   = 12'h000;
  localparam logic [11:0] A_CTRL   = 12'h004;
  localparam logic [11:0] A_FLAG   = 12'h018;
  localparam logic [11:0] A_BAUD_I = 12'h024;
  localparam logic [11:0] A_BAUD_F = 12'h028;
  localparam logic [11:0] A_LINE   = 12'h02C;
  localparam logic [11:0] A_LEVEL  = 12'h034;
  localparam logic [11:0] A_MASK   = 12'h038;
  localparam logic [11:0] A_RAW    = 12'h03C;
  localparam logic [11:0] A_MASKED = 12'h040;
  localparam logic [11:0] A_CLEAR  = 12'h044;
  localparam logic [11:0] A_DMA    = 12'h048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        id_variant = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        rx_break = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_char;
  logic        irq;

  int n_total = 0;
  int n_fail  = 0;
  logic        last_err;
  logic [31:0] rv;

  always #10 clk = ~clk;

  uart_regfile dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .id_variant (id_variant),
    .rx_valid   (rx_valid),
    .rx_char    (rx_char),
    .rx_break   (rx_break),
    .tx_valid   (tx_valid),
    .tx_char    (tx_char),
    .irq        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    last_err = bus_err;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    last_err = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic rx(input logic [7:0] ch, input logic brk);
    @(negedge clk);
    rx_valid = !brk; rx_break = brk; rx_char = ch;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 tx_valid", 32'(tx_valid), 32'h0);
    chk("R1 bus_err", 32'(bus_err), 32'h0);
    rd(A_FLAG, rv);  chk("R1 flag", rv, 32'h90);
    rd(A_CTRL, rv);  chk("R1 ctrl", rv, 32'h300);
    rd(A_LEVEL, rv); chk("R1 level", rv, 32'h12);
    rd(A_LINE, rv);  chk("R1 line", rv, 32'h0);
    rd(A_MASK, rv);  chk("R1 mask", rv, 32'h0);
    rd(A_RAW, rv);   chk("R1 raw", rv, 32'h0);
    rd(A_DMA, rv);   chk("R1 dma", rv, 32'h0);
  endtask

  task automatic t_widths;
    wr(A_CTRL, 32'hFFFF_FFFF);   rd(A_CTRL, rv);   chk("R14 ctrl", rv, 32'hFFFF_FFFF);
    wr(A_BAUD_I, 32'hFFFF_FFFF); rd(A_BAUD_I, rv); chk("R14 baud_i", rv, 32'hFFFF);
    wr(A_BAUD_F, 32'hFFFF_FFFF); rd(A_BAUD_F, rv); chk("R14 baud_f", rv, 32'h3F);
    wr(A_LEVEL, 32'hFFFF_FFFF);  rd(A_LEVEL, rv);  chk("R14 level", rv, 32'h3F);
    wr(A_DMA, 32'hFFFF_FFFF);    rd(A_DMA, rv);    chk("R14 dma", rv, 32'h7);
    wr(A_MASK, 32'hFFFF_FFFF);   rd(A_MASK, rv);   chk("R14 mask", rv, 32'h7FF);
    wr(A_MASK, 32'h0);
    wr(A_CTRL, 32'h300);
    wr(A_LEVEL, 32'h12);
  endtask

  task automatic t_id;
    logic [7:0] tbl0 [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] tbl1 [8] = '{8'h11, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    id_variant = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), rv); chk("R11 id variant0", rv, 32'(tbl0[i]));
    end
    id_variant = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), rv); chk("R11 id variant1", rv, 32'(tbl1[i]));
    end
    id_variant = 1'b0;
  endtask

  task automatic t_single_slot;
    rx(8'h41, 1'b0);
    rd(A_FLAG, rv); chk("R3 R4 flag one held", rv, 32'hC0);
    rd(A_RAW, rv);  chk("R8 raw rx at trigger 1", rv, 32'h10);
    rx(8'h42, 1'b0);
    rd(A_RAW, rv);  chk("R6 overrun raw", rv, 32'h410);
    rd(A_DATA, rv); chk("R3 held entry kept", rv, 32'h41);
    rd(A_RAW, rv);  chk("R8 rx cleared after pop", rv, 32'h400);
    rd(A_DATA, rv); chk("R7 empty read", rv, 32'h0);
    rd(A_FLAG, rv); chk("R7 flag after empty read", rv, 32'h90);
    wr(A_CLEAR, 32'h400);
    rd(A_RAW, rv);  chk("R6 overrun cleared", rv, 32'h0);
  endtask

  task automatic t_break;
    @(negedge clk);
    rx_valid = 1'b1; rx_break = 1'b1; rx_char = 8'h55;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
    rd(A_RAW, rv);  chk("R5 no overrun from break with char", rv, 32'h10);
    rd(A_DATA, rv); chk("R5 break entry", rv, 32'h400);
    rd(A_FLAG, rv); chk("R5 single entry only", rv, 32'h90);
  endtask

  task automatic t_flag_ignored;
    wr(A_FLAG, 32'hFFFF_FFFF);
    chk("R12 no error", 32'(last_err), 32'h0);
    rd(A_FLAG, rv); chk("R12 flag unchanged empty", rv, 32'h90);
    rx(8'h77, 1'b0);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, rv); chk("R12 flag unchanged held", rv, 32'hC0);
    rd(A_DATA, rv); chk("R12 data intact", rv, 32'h77);
  endtask

  task automatic t_queue16;
    wr(A_LINE, 32'h10);
    rd(A_FLAG, rv); chk("R4 flag enabled empty", rv, 32'h90);
    for (int i = 0; i < 7; i++) rx(8'h30 + 8'(i), 1'b0);
    rd(A_RAW, rv); chk("R8 below trigger 8", rv, 32'h0);
    rx(8'h37, 1'b0);
    rd(A_RAW, rv); chk("R8 reached trigger 8", rv, 32'h10);
    for (int i = 8; i < 16; i++) rx(8'h30 + 8'(i), 1'b0);
    rd(A_FLAG, rv); chk("R4 flag full 16", rv, 32'hC0);
    rx(8'h99, 1'b0);
    rd(A_RAW, rv); chk("R6 overrun at 16", rv, 32'h410);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, rv); chk("R2 order", rv, 32'h30 + 32'(i));
      if (i == 7) begin
        rd(A_RAW, rv); chk("R8 held at count 8", rv & 32'h10, 32'h10);
      end
      if (i == 8) begin
        rd(A_RAW, rv); chk("R8 cleared below 8", rv & 32'h10, 32'h0);
      end
    end
    rd(A_FLAG, rv); chk("R2 drained", rv, 32'h90);
    rd(A_DATA, rv); chk("R7 empty after drain", rv, 32'h0);
    wr(A_CLEAR, 32'h7FF);
    wr(A_LINE, 32'h0);
  endtask

  task automatic t_irq;
    wr(A_MASK, 32'h10);
    chk("R9 irq idle", 32'(irq), 32'h0);
    rx(8'h61, 1'b0);
    chk("R9 irq one cycle late", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R9 irq asserted", 32'(irq), 32'h1);
    rd(A_MASKED, rv); chk("R9 masked status", rv, 32'h10);
    wr(A_MASK, 32'h0);
    @(negedge clk);
    chk("R9 irq dropped when masked", 32'(irq), 32'h0);
    rd(A_DATA, rv); chk("R9 drain", rv, 32'h61);
  endtask

  task automatic t_tx;
    wr(A_DATA, 32'h0000_01A5);
    chk("R10 tx_valid", 32'(tx_valid), 32'h1);
    chk("R10 tx_char", 32'(tx_char), 32'hA5);
    @(negedge clk);
    chk("R10 tx_valid one cycle", 32'(tx_valid), 32'h0);
    rd(A_RAW, rv); chk("R10 raw tx", rv, 32'h20);
    wr(A_CLEAR, 32'h20);
    rd(A_RAW, rv); chk("R10 raw tx cleared", rv, 32'h0);
  endtask

  task automatic t_unmapped;
    rd(12'h030, rv);
    chk("R13 read zero", rv, 32'h0);
    chk("R13 read err", 32'(last_err), 32'h1);
    wr(12'h030, 32'hFFFF_FFFF);
    chk("R13 write err", 32'(last_err), 32'h1);
    rd(12'h800, rv);
    chk("R13 far read err", 32'(last_err), 32'h1);
    rd(12'h006, rv);
    chk("R13 misaligned err", 32'(last_err), 32'h1);
    chk("R13 misaligned zero", rv, 32'h0);
    rd(A_CTRL, rv);
    chk("R13 mapped no err", 32'(last_err), 32'h0);
    chk("R13 ctrl untouched", rv, 32'h300);
    @(negedge clk);
    chk("R13 err one cycle", 32'(bus_err), 32'h0);
  endtask

  initial begin
    t_reset();
    t_widths();
    t_id();
    t_single_slot();
    t_break();
    t_flag_ignored();
    t_queue16();
    t_irq();
    t_tx();
    t_unmapped();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule